// File: doc/BRIEF.md
# Event Packet Timestamp Queue

This block holds start-of-packet times for precision-time event messages in both directions. Each time the MAC-side logic flags an event packet, the block stores the current seconds and nanoseconds count together with the packet's 16-bit sequence number, its 4-bit message type and whether it was sent or received. Software can then match each stored time to a transmit packet it is still holding.

Software works through a small 16-bit register port. A status register shows whether anything is queued. Setting a start bit in the control register freezes the head entry into a set of read registers. Setting an end bit pops that entry. Writing zero returns the control register to idle so the next start is recognised. The queue is a ring of `DEPTH` entries. When the ring is full, new events are dropped and a sticky overflow flag is raised.

Top module: `evt_tstamp_queue`

## Requirements
- R1: After reset the status register (address 1) reads 0, and every read register at addresses 2 to 7 reads 0.
- R2: A flagged event is stored only while `en_global` is 1 and the enable for its own direction is 1 (`en_tx` when `cap_is_tx`=1, else `en_rx`). Any other flagged event leaves the queue unchanged.
- R3: Status bit 0 reads 1 exactly while at least one entry is queued.
- R4: Writing address 0 with bit 0 set, while the stored control bit 0 is clear, copies the head entry into the read registers. Those registers are: address 2 = nanoseconds[15:0], 3 = nanoseconds[31:16], 4 = seconds[15:0], 5 = seconds[31:16].
- R5: Address 6 returns the sequence number exactly as it was captured. Address 7 returns the message type in bits 15:12 and the transmit flag in bit 11, with all other bits 0.
- R6: The read registers keep their values until the next start, even when new entries are pushed in the meantime.
- R7: Writing address 0 with bit 1 set, while the stored control bit 1 is clear, pops the head entry. Writing bit 1 again without first writing zero pops nothing more. Entries leave in the order they arrived.
- R8: An event that arrives while `DEPTH` entries are queued and no pop happens in the same cycle is dropped, and status bit 1 is set. That bit stays set until software writes address 1 with bit 1 set.
- R9: A start or end on an empty queue changes neither the read registers nor the status register.
- R10: When the queue is full, an event that arrives in the same cycle as a pop is accepted and placed at the tail, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Event packet start seen this cycle |
| cap_is_tx | input | 1 | 1 = transmit direction, 0 = receive |
| cap_seq | input | 16 | Sequence number of the packet |
| cap_mtype | input | 4 | Message type of the packet |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 32 | Current time, nanoseconds |
| en_global | input | 1 | Global capture enable |
| en_tx | input | 1 | Transmit capture enable |
| en_rx | input | 1 | Receive capture enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |

## Verification
The bench builds the block with `DEPTH` set to 4. With that depth, filling the ring, overflowing it, and popping while full each take only a handful of events, so the drop path, the sticky flag and the push-with-pop-on-full case are all exercised. A ring pointer wrap is also reached, because more than four entries pass through the ring over the run.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] ns;
        logic [15:0] seq;
        logic [3:0]  mtype;
        logic        is_tx;
    } tsq_entry_t;

    localparam int ENTRY_W = $bits(tsq_entry_t);

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_NS_LO  = 3'd2,
        A_NS_HI  = 3'd3,
        A_SEC_LO = 3'd4,
        A_SEC_HI = 3'd5,
        A_SEQ    = 3'd6,
        A_INFO   = 3'd7
    } tsq_addr_e;

    localparam int CTRL_START = 0;
    localparam int CTRL_END   = 1;
    localparam int STAT_NE    = 0;
    localparam int STAT_OVF   = 1;
    localparam int INFO_TYPE  = 12;
    localparam int INFO_DIR   = 11;

    function automatic logic [15:0] info_word(tsq_entry_t e);
        logic [15:0] w;
        w = '0;
        w[INFO_TYPE +: 4] = e.mtype;
        w[INFO_DIR]       = e.is_tx;
        return w;
    endfunction

endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo
    import tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  tsq_entry_t                   din,
    output tsq_entry_t                   dout,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH+1);

    tsq_entry_t       mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= nxt(wptr);
            end
            if (pop) rptr <= nxt(rptr);
            case ({push, pop})
                2'b10:   fill <= fill + FW'(1);
                2'b01:   fill <= fill - FW'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign dout  = mem[rptr];
    assign full  = (fill == FW'(DEPTH));
    assign empty = (fill == '0);
endmodule

// File: rtl/tsq_regif.sv
module tsq_regif
    import tsq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  tsq_entry_t  head,
    input  logic        q_empty,
    input  logic        ovf_set,
    output logic        start_evt,
    output logic        end_evt,
    output logic        ovf_clr,
    output logic        ovf_flag,
    output tsq_entry_t  snap,
    output logic [15:0] reg_rdata
);
    logic [1:0] ctrl_q;
    logic       ctrl_wr;

    assign ctrl_wr   = reg_wr && (tsq_addr_e'(reg_addr) == A_CTRL);
    assign start_evt = ctrl_wr && reg_wdata[CTRL_START] && !ctrl_q[CTRL_START];
    assign end_evt   = ctrl_wr && reg_wdata[CTRL_END]   && !ctrl_q[CTRL_END];
    assign ovf_clr   = reg_wr && (tsq_addr_e'(reg_addr) == A_STAT) && reg_wdata[STAT_OVF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            snap     <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata[1:0];
            if (start_evt && !q_empty) snap <= head;
            if (ovf_set)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (tsq_addr_e'(reg_addr))
            A_CTRL:   reg_rdata[1:0] = ctrl_q;
            A_STAT: begin
                reg_rdata[STAT_NE]  = !q_empty;
                reg_rdata[STAT_OVF] = ovf_flag;
            end
            A_NS_LO:  reg_rdata = snap.ns[15:0];
            A_NS_HI:  reg_rdata = snap.ns[31:16];
            A_SEC_LO: reg_rdata = snap.sec[15:0];
            A_SEC_HI: reg_rdata = snap.sec[31:16];
            A_SEQ:    reg_rdata = snap.seq;
            A_INFO:   reg_rdata = info_word(snap);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_tstamp_queue.sv
module evt_tstamp_queue
    import tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_valid,
    input  logic        cap_is_tx,
    input  logic [15:0] cap_seq,
    input  logic [3:0]  cap_mtype,
    input  logic [31:0] now_sec,
    input  logic [31:0] now_ns,
    input  logic        en_global,
    input  logic        en_tx,
    input  logic        en_rx,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);
    localparam int FW = $clog2(DEPTH+1);

    tsq_entry_t     cap_entry, head, snap;
    logic           cap_hit, push_ok, pop_ok, ovf_set;
    logic           start_evt, end_evt, ovf_clr, ovf_flag;
    logic           q_full, q_empty;
    logic [FW-1:0]  fill;

    assign cap_hit = cap_valid && en_global && (cap_is_tx ? en_tx : en_rx);
    assign pop_ok  = end_evt && !q_empty;
    assign push_ok = cap_hit && (!q_full || pop_ok);
    assign ovf_set = cap_hit && !push_ok;

    always_comb begin
        cap_entry.sec   = now_sec;
        cap_entry.ns    = now_ns;
        cap_entry.seq   = cap_seq;
        cap_entry.mtype = cap_mtype;
        cap_entry.is_tx = cap_is_tx;
    end

    tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push_ok), .pop(pop_ok),
        .din(cap_entry), .dout(head), .fill(fill),
        .full(q_full), .empty(q_empty)
    );

    tsq_regif u_regif (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .head(head), .q_empty(q_empty),
        .ovf_set(ovf_set), .start_evt(start_evt), .end_evt(end_evt),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .snap(snap),
        .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker
    import tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       push_ok,
    input logic                       pop_ok,
    input logic                       end_evt,
    input logic                       start_evt,
    input logic                       ovf_flag,
    input logic                       ovf_clr,
    input logic                       cap_valid,
    input logic                       en_global,
    input tsq_entry_t                 snap
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= ($clog2(DEPTH+1))'(DEPTH));  // R8

    AST_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop_ok) |=> (fill != '0));  // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);  // R8

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !start_evt |=> $stable(snap));  // R6

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !en_global) |=> (fill <= $past(fill)));  // R2

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (fill == '0 && end_evt && !push_ok) |=> (fill == '0));  // R9
endmodule

bind evt_tstamp_queue tsq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .fill(fill), .push_ok(push_ok), .pop_ok(pop_ok),
    .end_evt(end_evt), .start_evt(start_evt), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr), .cap_valid(cap_valid), .en_global(en_global),
    .snap(snap)
);

// File: tb/evt_tstamp_queue_tb.sv
module evt_tstamp_queue_tb;
    import tsq_pkg::*;
    localparam int DEPTH = 4;

    logic        clk = 0, rst = 1;
    logic        cap_valid = 0, cap_is_tx = 0;
    logic [15:0] cap_seq = 0;
    logic [3:0]  cap_mtype = 0;
    logic [31:0] now_sec = 0, now_ns = 0;
    logic        en_global = 1, en_tx = 1, en_rx = 1;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    tsq_entry_t exp_q[$];
    tsq_entry_t last_seen;
    int model_fill = 0;

    always #2.5 clk = ~clk;

    evt_tstamp_queue #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: flags one event and records what the queue should now hold
    task automatic capture(bit tx, logic [15:0] seq, logic [3:0] mt,
                           logic [31:0] s, logic [31:0] ns);
        tsq_entry_t e;
        bit hit;
        @(negedge clk);
        cap_valid = 1; cap_is_tx = tx; cap_seq = seq; cap_mtype = mt;
        now_sec = s; now_ns = ns;
        e = '{sec: s, ns: ns, seq: seq, mtype: mt, is_tx: tx};
        hit = en_global && (tx ? en_tx : en_rx);
        if (hit && model_fill < DEPTH) begin
            exp_q.push_back(e);
            model_fill++;
        end
        @(negedge clk);
        cap_valid = 0;
    endtask

    task automatic check_view(string req, tsq_entry_t e);
        logic [15:0] d;
        rd(A_NS_LO, d);  chk({req, " ns lo"}, d, e.ns[15:0]);
        rd(A_NS_HI, d);  chk({req, " ns hi"}, d, e.ns[31:16]);
        rd(A_SEC_LO, d); chk({req, " sec lo"}, d, e.sec[15:0]);
        rd(A_SEC_HI, d); chk({req, " sec hi"}, d, e.sec[31:16]);
        rd(A_SEQ, d);    chk("R5 seq", d, e.seq);
        rd(A_INFO, d);   chk("R5 info", d, {e.mtype, e.is_tx, 11'd0});
    endtask

    // monitor: pops the expected head and compares the presented entry
    task automatic read_head(string req);
        tsq_entry_t e;
        wr(A_CTRL, 16'h1);
        e = exp_q.pop_front();
        model_fill--;
        check_view(req, e);
        last_seen = e;
        wr(A_CTRL, 16'h2);
        wr(A_CTRL, 16'h0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(A_STAT, d); chk("R1 status", d, 0);
        for (int a = 2; a < 8; a++) begin
            rd(3'(a), d); chk("R1 view", d, 0);
        end
        // R2 filtering
        en_global = 0;
        capture(0, 16'h0101, 4'h1, 32'h1, 32'h1);
        en_global = 1; en_tx = 0;
        capture(1, 16'h0202, 4'h2, 32'h2, 32'h2);
        rd(A_STAT, d); chk("R2 nothing stored", d, 0);
        en_tx = 1; en_rx = 0;
        capture(0, 16'h0303, 4'h3, 32'h3, 32'h3);
        rd(A_STAT, d); chk("R2 rx disabled", d, 0);
        en_rx = 1;
        // R3/R4/R5/R7 order
        capture(1, 16'hA1B2, 4'h0, 32'h1234_5678, 32'h0ABC_DEF0);
        rd(A_STAT, d); chk("R3 nonempty", d, 1);
        capture(0, 16'h00FF, 4'hB, 32'hCAFE_0001, 32'h3B9A_C9FF);
        capture(1, 16'hFFFF, 4'h3, 32'h0000_0000, 32'h0000_0010);
        // R7 repeated end without idle pops only once
        wr(A_CTRL, 16'h1);
        check_view("R4", exp_q[0]);
        void'(exp_q.pop_front()); model_fill--;
        wr(A_CTRL, 16'h2);
        wr(A_CTRL, 16'h2);
        wr(A_CTRL, 16'h0);
        read_head("R7 order");
        read_head("R7 order");
        rd(A_STAT, d); chk("R3 empty after pops", d, 0);
        // R6 freeze
        capture(0, 16'h1111, 4'h2, 32'h11, 32'h22);
        wr(A_CTRL, 16'h1);
        capture(1, 16'h2222, 4'h9, 32'h33, 32'h44);
        check_view("R6 frozen", exp_q[0]);
        void'(exp_q.pop_front()); model_fill--;
        wr(A_CTRL, 16'h2); wr(A_CTRL, 16'h0);
        read_head("R6 next");
        // R9 empty
        wr(A_CTRL, 16'h1); wr(A_CTRL, 16'h2); wr(A_CTRL, 16'h0);
        rd(A_STAT, d); chk("R9 status", d, 0);
        check_view("R9 view kept", last_seen);
        // R8 overflow
        for (int i = 0; i < DEPTH + 1; i++)
            capture(i[0], 16'(16'h4000 + i), 4'(i), 32'(100 + i), 32'(200 + i));
        rd(A_STAT, d); chk("R8 overflow flag", d, 3);
        for (int i = 0; i < DEPTH; i++) read_head("R8 kept");
        rd(A_STAT, d); chk("R8 sticky", d, 2);
        wr(A_STAT, 16'h2);
        rd(A_STAT, d); chk("R8 cleared", d, 0);
        // R10 push with pop while full
        for (int i = 0; i < DEPTH; i++)
            capture(0, 16'(16'h5000 + i), 4'h4, 32'(300 + i), 32'(400 + i));
        wr(A_CTRL, 16'h1);
        check_view("R10 head", exp_q[0]);
        void'(exp_q.pop_front());
        @(negedge clk);
        reg_wr = 1; reg_addr = A_CTRL; reg_wdata = 16'h2;
        cap_valid = 1; cap_is_tx = 1; cap_seq = 16'h5ABC; cap_mtype = 4'hD;
        now_sec = 32'h0DEA_DBEE; now_ns = 32'h0123_4567;
        exp_q.push_back('{sec: 32'h0DEA_DBEE, ns: 32'h0123_4567,
                          seq: 16'h5ABC, mtype: 4'hD, is_tx: 1'b1});
        @(negedge clk);
        reg_wr = 0; cap_valid = 0;
        wr(A_CTRL, 16'h0);
        rd(A_STAT, d); chk("R10 no overflow", d, 1);
        for (int i = 0; i < DEPTH; i++) read_head("R10 tail");
        rd(A_STAT, d); chk("R10 drained", d, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule